// File: doc/BRIEF.md
# Fractional Clock Divider with Synchronized Update

This block derives a slower clock from a fast source clock by a programmable factor made of an integer part and a 9-bit fraction counted in 1/512 steps. The output toggles so that, on average, one output period spans twice the factor in source cycles. Each half-period lasts either the integer part or one cycle more. A 9-bit accumulator adds the fraction once per half-period, and its carry adds the extra cycle. The short-term period error therefore stays below one source cycle.

Settings are written from a register clock domain. If the source enable is low, a write takes effect with no handshake. If the source enable is high, the write sends a toggle request into the source domain and raises a busy flag. The request waits there until the source is locked. The divider then switches to the new setting at the next half-period boundary, clears the accumulator, and returns an acknowledge that lowers busy. When both fields are zero the source clock passes straight through. The output is held low whenever the source is disabled or not locked.

Top module: `fdiv_top`

## Requirements
- R1: After reset, `busy` is 0, `clk_out` is 0 and the active setting is integer 0, fraction 0 (bypass).
- R2: With the setting integer 0 and fraction 0, and the source enabled and locked, `clk_out` is high in the high phase of `src_clk` and low in its low phase.
- R3: Each half-period of `clk_out` lasts `wr_int` source cycles plus a carry. The carry comes from a 9-bit accumulator that starts at 0 when the setting is applied and adds `wr_frac` once per half-period. Any 512 consecutive half-periods therefore add up to 512·`wr_int` + `wr_frac` source cycles.
- R4: An integer field of 0 with a nonzero fraction behaves as an integer field of 1 with the same fraction.
- R5: A write while `src_en` is 1 raises `busy` from the next register clock edge. `busy` stays at 1 for as long as `src_lock` is 0.
- R6: A write while `src_en` is 0 becomes the active setting without raising `busy`.
- R7: `clk_out` stays 0 while `src_en` is 0 or `src_lock` is 0.
- R8: A setting written while the divider runs leaves the half-period in progress at its old length. The next half-period uses the new setting, with the accumulator cleared.
- R9: A write accepted while `busy` is 1 is ignored and does not extend `busy`.
- R10: Once the source is locked and running, `busy` returns to 0 within 20 register clock cycles of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-side clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| wr_en | input | 1 | One-cycle write strobe for a new divider setting |
| wr_int | input | 8 | Integer part of the half-period factor |
| wr_frac | input | 9 | Fractional part in 1/512 units |
| src_en | input | 1 | Source enable (register domain) |
| busy | output | 1 | High while a setting transfer is in progress |
| src_clk | input | 1 | Fast source clock |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| src_lock | input | 1 | Source lock indication |
| clk_out | output | 1 | Divided (or bypassed) output clock |

## Verification
The divider is run with several settings. A whole integer (3) shows whether the counter alone is right. The fraction 1/512 at integer 2 exercises a single carry over a long run. The fraction 511/512 at integer 0 makes almost every half-period carry, and it also shows whether a zero integer is promoted to one. The fraction 1/2 at integer 4 gives an alternating pattern of half-period lengths. Each measured half-period is compared with a behavioural accumulator in the bench, and the 512-half sums expose any accumulator error that drifts over time. A change from integer 2 to integer 5 with fraction 1/4 while the divider is running separates three cases: switching at a boundary, switching mid-half, and failing to clear the accumulator. A second write issued during busy must leave no trace.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FDIV_INT_W   = 8;
  localparam int FDIV_FRAC_W  = 9;
  localparam int FDIV_CNT_W   = FDIV_INT_W + 1;
  localparam int FDIV_SYNC_N  = 2;

  typedef struct packed {
    logic [FDIV_INT_W-1:0]  ipart;
    logic [FDIV_FRAC_W-1:0] fpart;
  } fdiv_cfg_t;

  // Integer part with zero promoted to one, so no half is shorter than a cycle
  function automatic logic [FDIV_CNT_W-1:0] fdiv_eff(input fdiv_cfg_t c);
    if (c.ipart == '0) return FDIV_CNT_W'(1);
    return FDIV_CNT_W'(c.ipart);
  endfunction

  function automatic logic fdiv_is_bypass(input fdiv_cfg_t c);
    return (c.ipart == '0) && (c.fpart == '0);
  endfunction
endpackage

// File: rtl/fdiv_sync.sv
module fdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/fdiv_reg_if.sv
module fdiv_reg_if
  import fdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  fdiv_cfg_t wr_cfg,
  input  logic      src_en,
  input  logic      ack_s,
  output fdiv_cfg_t hold_cfg,
  output logic      req_tgl,
  output logic      busy
);
  logic accept;
  logic req_n;

  // Writes during a transfer are dropped so the held value stays stable
  always_comb begin
    accept = wr_en && !busy;
    req_n  = req_tgl ^ (accept && src_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cfg <= '0;
      req_tgl  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (accept) hold_cfg <= wr_cfg;
      req_tgl <= req_n;
      busy    <= req_n ^ ack_s;
    end
  end
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
  import fdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_s,
  input  logic      lock_s,
  input  logic      req_s,
  input  fdiv_cfg_t hold_cfg,
  output logic      run,
  output logic      byp,
  output logic      div_clk,
  output logic      ack_tgl,
  output logic      apply
);
  fdiv_cfg_t                cur_cfg;
  fdiv_cfg_t                nxt_cfg;
  logic                     req_d;
  logic                     pend;
  logic                     pend_any;
  logic                     boundary;
  logic                     take_hold;
  logic [FDIV_CNT_W-1:0]    cnt;
  logic [FDIV_FRAC_W-1:0]   acc;
  logic [FDIV_FRAC_W:0]     sum;
  logic [FDIV_CNT_W-1:0]    next_len;

  always_comb begin
    pend_any  = pend || (req_s ^ req_d);
    boundary  = run && (cnt == FDIV_CNT_W'(1));
    apply     = pend_any && (!en_s || (lock_s && (!run || boundary)));
    take_hold = apply || !en_s;
    nxt_cfg   = take_hold ? hold_cfg : cur_cfg;
    sum       = {1'b0, (apply ? '0 : acc)} + {1'b0, nxt_cfg.fpart};
    next_len  = fdiv_eff(nxt_cfg) + FDIV_CNT_W'(sum[FDIV_FRAC_W]);
  end

  // Request edge detect, pending flag and acknowledge toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      pend    <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_d   <= req_s;
      pend    <= pend_any && !apply;
      if (apply) ack_tgl <= ~ack_tgl;
    end
  end

  // Active setting; copied freely while the source is disabled
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cfg <= '0;
      byp     <= 1'b1;
      run     <= 1'b0;
    end else begin
      cur_cfg <= nxt_cfg;
      byp     <= fdiv_is_bypass(nxt_cfg);
      run     <= en_s && lock_s;
    end
  end

  // Half-period counter and fractional accumulator
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= FDIV_CNT_W'(1);
      acc     <= '0;
      div_clk <= 1'b0;
    end else if (!run) begin
      cnt     <= FDIV_CNT_W'(1);
      acc     <= '0;
      div_clk <= 1'b0;
    end else if (boundary) begin
      cnt     <= next_len;
      acc     <= sum[FDIV_FRAC_W-1:0];
      div_clk <= ~div_clk;
    end else begin
      cnt     <= cnt - FDIV_CNT_W'(1);
    end
  end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
(
  input  logic                   reg_clk,
  input  logic                   reg_rst,
  input  logic                   wr_en,
  input  logic [FDIV_INT_W-1:0]  wr_int,
  input  logic [FDIV_FRAC_W-1:0] wr_frac,
  input  logic                   src_en,
  output logic                   busy,
  input  logic                   src_clk,
  input  logic                   src_rst,
  input  logic                   src_lock,
  output logic                   clk_out
);
  fdiv_cfg_t wr_cfg;
  fdiv_cfg_t hold_cfg;
  logic      req_tgl;
  logic      ack_tgl;
  logic      ack_sync;
  logic      en_sync;
  logic      lock_sync;
  logic      req_sync;
  logic      core_run;
  logic      core_byp;
  logic      core_div;
  logic      core_apply;
  logic [2:0] src_sync_q;

  assign wr_cfg = '{ipart: wr_int, fpart: wr_frac};

  fdiv_reg_if u_reg (
    .clk      (reg_clk),
    .rst      (reg_rst),
    .wr_en    (wr_en),
    .wr_cfg   (wr_cfg),
    .src_en   (src_en),
    .ack_s    (ack_sync),
    .hold_cfg (hold_cfg),
    .req_tgl  (req_tgl),
    .busy     (busy)
  );

  fdiv_sync #(.W(3), .STAGES(FDIV_SYNC_N)) u_sync_src (
    .clk (src_clk),
    .rst (src_rst),
    .d   ({src_en, src_lock, req_tgl}),
    .q   (src_sync_q)
  );

  assign en_sync   = src_sync_q[2];
  assign lock_sync = src_sync_q[1];
  assign req_sync  = src_sync_q[0];

  fdiv_sync #(.W(1), .STAGES(FDIV_SYNC_N)) u_sync_reg (
    .clk (reg_clk),
    .rst (reg_rst),
    .d   (ack_tgl),
    .q   (ack_sync)
  );

  fdiv_core u_core (
    .clk      (src_clk),
    .rst      (src_rst),
    .en_s     (en_sync),
    .lock_s   (lock_sync),
    .req_s    (req_sync),
    .hold_cfg (hold_cfg),
    .run      (core_run),
    .byp      (core_byp),
    .div_clk  (core_div),
    .ack_tgl  (ack_tgl),
    .apply    (core_apply)
  );

  assign clk_out = core_run ? (core_byp ? src_clk : core_div) : 1'b0;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
(
  input logic      reg_clk,
  input logic      reg_rst,
  input logic      src_clk,
  input logic      src_rst,
  input logic      wr_en,
  input logic      src_en,
  input logic      busy,
  input fdiv_cfg_t hold_cfg,
  input logic      en_sync,
  input logic      lock_sync,
  input logic      core_run,
  input logic      core_div,
  input logic      core_apply
);
  // R5: a write with the source enabled and no transfer open raises busy
  a_r5_busy_rises: assert property (@(posedge reg_clk) disable iff (reg_rst)
    (wr_en && src_en && !busy) |=> busy);

  // R9: the held setting cannot move while a transfer is open
  a_r9_hold_frozen: assert property (@(posedge reg_clk) disable iff (reg_rst)
    busy |=> $stable(hold_cfg));

  // R7: losing enable or lock stops the divider on the next edge
  a_r7_stop_on_idle: assert property (@(posedge src_clk) disable iff (src_rst)
    !(en_sync && lock_sync) |=> !core_run);

  // R7: a stopped divider keeps its internal clock low
  a_r7_div_low_idle: assert property (@(posedge src_clk) disable iff (src_rst)
    (!core_run && $past(!core_run)) |-> !core_div);

  // R8: a setting applied while running lands on a half-period boundary
  a_r8_apply_on_edge: assert property (@(posedge src_clk) disable iff (src_rst)
    (core_run && en_sync && core_apply) |=> (core_div != $past(core_div)));
endmodule

bind fdiv_top fdiv_chk u_chk (
  .reg_clk    (reg_clk),
  .reg_rst    (reg_rst),
  .src_clk    (src_clk),
  .src_rst    (src_rst),
  .wr_en      (wr_en),
  .src_en     (src_en),
  .busy       (busy),
  .hold_cfg   (hold_cfg),
  .en_sync    (en_sync),
  .lock_sync  (lock_sync),
  .core_run   (core_run),
  .core_div   (core_div),
  .core_apply (core_apply)
);

// File: tb/fdiv_top_tb.sv
module fdiv_top_tb;
  logic       reg_clk = 1'b0;
  logic       src_clk = 1'b0;
  logic       reg_rst = 1'b1;
  logic       src_rst = 1'b1;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_int  = '0;
  logic [8:0] wr_frac = '0;
  logic       src_en  = 1'b0;
  logic       src_lock = 1'b0;
  logic       busy;
  logic       clk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 reg_clk = ~reg_clk;   // 50 MHz register clock
  always #3  src_clk = ~src_clk;   // faster source clock

  fdiv_top u_dut (
    .reg_clk (reg_clk), .reg_rst (reg_rst), .wr_en (wr_en),
    .wr_int (wr_int), .wr_frac (wr_frac), .src_en (src_en),
    .busy (busy), .src_clk (src_clk), .src_rst (src_rst),
    .src_lock (src_lock), .clk_out (clk_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_write(input int iv, input int fv);
    @(negedge reg_clk);
    wr_en = 1'b1; wr_int = 8'(iv); wr_frac = 9'(fv);
    @(negedge reg_clk);
    wr_en = 1'b0;
  endtask

  task automatic src_wait(input int n);
    for (int i = 0; i < n; i++) @(posedge src_clk);
  endtask

  // Behavioural model: half k lasts eff + carry of the k-th fraction add.
  // old_len > 0: halves of that length are skipped until the first new one.
  task automatic measure(input int iv, input int fv, input int old_len,
                         input int nh, input string tag);
    int eff = (iv == 0) ? 1 : iv;
    int acc = 0; int len = 0; int k = 0; int sum = 0;
    int phase = 0; int guard = 0; int c; int exp;
    logic prev, now;
    @(posedge src_clk); #1; prev = clk_out;
    while (k < nh && guard < 20000) begin
      @(posedge src_clk); #1; now = clk_out;
      guard++; len++;
      if (now !== prev) begin
        if (phase == 0) begin
          if (old_len > 0 || now === 1'b1) phase = (old_len > 0) ? 1 : 2;
          len = 0;
        end else if (phase == 1 && len == old_len) begin
          len = 0;
        end else begin
          phase = 2; k++;
          acc += fv;
          c = (acc >= 512) ? 1 : 0;
          if (c == 1) acc -= 512;
          exp = eff + c;
          chk($sformatf("%s half %0d length", tag, k), len, exp);
          sum += len; len = 0;
        end
        prev = now;
      end
    end
    chk({tag, " measurement completed"}, (k == nh) ? 1 : 0, 1);
    if (nh == 512) chk({tag, " sum over 512 halves"}, sum, 512 * eff + fv);
  endtask

  task automatic wait_busy_low(input int max, input string tag);
    int n = 0;
    while (busy !== 1'b0 && n < max) begin @(negedge reg_clk); n++; end
    chk({tag, " busy cleared"}, (busy === 1'b0) ? 1 : 0, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int hi_ok; int lo_ok; int busy_seen;
    repeat (5) @(negedge reg_clk);
    reg_rst = 1'b0; src_rst = 1'b0;
    @(negedge reg_clk);
    // R1: reset state
    chk("R1 busy after reset", busy, 0);
    chk("R1 clk_out after reset", clk_out, 0);

    // R2: reset setting is bypass; output follows the source clock
    src_en = 1'b1; src_lock = 1'b1;
    src_wait(20);
    hi_ok = 0; lo_ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge src_clk); #1; if (clk_out === 1'b1) hi_ok++;
      @(negedge src_clk); #1; if (clk_out === 1'b0) lo_ok++;
    end
    chk("R2 bypass high phases", hi_ok, 20);
    chk("R2 bypass low phases", lo_ok, 20);
    chk("R1 busy idle in bypass", busy, 0);

    // R7: disabled source holds the output low
    src_en = 1'b0;
    src_wait(10);
    lo_ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge src_clk); #1; if (clk_out === 1'b0) lo_ok++;
      @(negedge src_clk); #1; if (clk_out === 1'b0) lo_ok++;
    end
    chk("R7 output low while disabled", lo_ok, 40);

    // R6: write with source disabled, no busy, applies directly
    do_write(3, 0);
    busy_seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge reg_clk); if (busy !== 1'b0) busy_seen++; end
    chk("R6 no busy for disabled write", busy_seen, 0);
    fork
      measure(3, 0, 0, 16, "R6");
      begin src_wait(4); src_en = 1'b1; end
    join

    // R3: fraction 1/512 over a full accumulator cycle
    src_en = 1'b0; src_wait(10);
    do_write(2, 1); src_wait(6);
    fork
      measure(2, 1, 0, 512, "R3");
      begin src_wait(4); src_en = 1'b1; end
    join

    // R4: integer 0 with fraction 511/512 acts as integer 1
    src_en = 1'b0; src_wait(10);
    do_write(0, 511); src_wait(6);
    fork
      measure(0, 511, 0, 512, "R4");
      begin src_wait(4); src_en = 1'b1; end
    join

    // R5: write while enabled but unlocked stays pending with busy high
    src_lock = 1'b0; src_wait(20);
    lo_ok = 0;
    for (int i = 0; i < 20; i++) begin @(posedge src_clk); #1; if (clk_out === 1'b0) lo_ok++; end
    chk("R7 output low while unlocked", lo_ok, 20);
    do_write(4, 256);
    chk("R5 busy raised after write", busy, 1);
    busy_seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge reg_clk); if (busy === 1'b1) busy_seen++; end
    chk("R5 busy held while unlocked", busy_seen, 30);
    fork
      measure(4, 256, 0, 16, "R5");
      begin src_wait(4); src_lock = 1'b1; end
      wait_busy_low(20, "R10 after lock");
    join

    // R8 and R9: change while running, second write during busy ignored
    src_en = 1'b0; src_wait(10);
    do_write(2, 0); src_wait(6);
    src_en = 1'b1; src_wait(30);
    fork
      measure(5, 128, 2, 16, "R8");
      begin
        do_write(5, 128);
        chk("R5 busy on live write", busy, 1);
        do_write(9, 0);
        wait_busy_low(20, "R10 live change");
        busy_seen = 0;
        for (int i = 0; i < 10; i++) begin @(negedge reg_clk); if (busy !== 1'b0) busy_seen++; end
        chk("R9 ignored write leaves no busy", busy_seen, 0);
      end
    join
    // R9: the dropped setting never appears
    measure(5, 128, 0, 0, "R9 settle");
    src_en = 1'b0; src_wait(10);
    src_en = 1'b1;
    fork
      measure(5, 128, 0, 8, "R9");
    join

    finish_run();
  end
endmodule